// File: doc/BRIEF.md
# Protected Pin Function Port Controller

This block is a register file that sits between a byte-wide synchronous register bus and a bank of 8-pin I/O ports. For every pin it holds a two-bit direction field, an output data bit, a mode bit that picks general-purpose I/O or peripheral use, and a function-select byte. It samples the pad inputs through a two-flop synchronizer so software can read them. It drives the pad output enables and output values, and it hands the mode bits and function bytes to an external multiplexer that does the actual peripheral routing.

The function bytes are guarded by a two-bit protect register. Its enable bit opens function writes. Its lock bit, while set, freezes the enable bit. A function byte therefore changes only after a two-write unlock: clear the lock first, then set the enable. Relocking is the same two steps in reverse. A direction field has three meaningful states: high-impedance with input protection, input, and output. A pin drives its pad only when it is in GPIO mode with its direction set to output.

Top module: `pinfn_ctrl`

## Requirements
- R1: After reset, every direction field is 00, all output data, mode and function bytes are 0, no output enable is asserted, and the protect register at 0x2FF reads 0x80.
- R2: The 16-bit direction register of port p is written and read one byte at a time: its low byte at 0x000+2*p and its high byte at 0x001+2*p. Pin n owns bits [2n+1:2n]. Both bytes read back as written.
- R3: A pad output enable is asserted exactly when the pin's mode bit is 0 and its direction field is 11. The codes 00 (high-impedance) and 10 (input) leave it deasserted.
- R4: The output data byte of port p at 0x040+p drives the pad output values of that port's 8 pins (bit n drives pin n) and reads back as written.
- R5: The input byte of port p at 0x060+p returns the pad levels through a two-flop synchronizer. A level applied before an edge is not yet returned by a read captured one edge later, and it is returned by a read captured three edges later.
- R6: The mode byte of port p at 0x080+p reads back as written. Bit n = 1 puts pin n in peripheral mode: it raises that pin's mode output to the multiplexer and removes its output enable.
- R7: In the protect register at 0x2FF, bit 6 is the function write enable and bit 7 is the lock. Bit 7 takes every written value. Bit 6 takes the written value only if bit 7 was 0 before the write. Bits 5..0 always read 0.
- R8: The function byte of pin n of port p lives at 0x200+8*p+n. A write to it is stored only while bit 6 of the protect register is 1 and is ignored otherwise. The byte always reads back, and it appears on the pin's 8-bit select output.
- R9: Starting from the reset lock, a single write of 0x40 to 0x2FF does not enable function writes. The sequence 0x00 then 0x40 enables them, and the sequence 0x00 then 0x80 relocks with the enable cleared.
- R10: Read data appears in the cycle after a read strobe and is 0 in any cycle that follows no read strobe. Reads of unmapped addresses, including registers of port numbers at or above NUM_PORTS, return 0, and writes to those addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, registered |
| pad_in_i | input | 8*NUM_PORTS | Pad input levels, asynchronous |
| pad_out_o | output | 8*NUM_PORTS | Pad output values |
| pad_oe_o | output | 8*NUM_PORTS | Pad output enables |
| periph_mode_o | output | 8*NUM_PORTS | Per-pin peripheral mode to the external multiplexer |
| psel_o | output | 64*NUM_PORTS | Per-pin function byte, pin k at bits [8k+7:8k] |

## Verification
The assertions assume one bus access at a time, with we_i and re_i never high together. They also assume that pad_in_i changes no closer to a clock edge than the synchronizer tolerates, so that the synchronizer latency property can compare the input register with the pad value of two cycles earlier. The bench drives every bus strobe, address and pad value on the falling edge, raises a single strobe per access, and holds each pad pattern for several cycles. The protect tests walk the lock and enable bits through each legal and illegal ordering and then try function writes in both states.

// File: rtl/pinfn_pkg.sv
package pinfn_pkg;
  localparam int PINS      = 8;
  localparam int ADDR_W    = 12;
  localparam int DIR_BYTES = (2 * PINS) / 8;

  localparam logic [ADDR_W-1:0] PROT_ADDR = 12'h2FF;

  // 2'b01 is unused and treated like high-impedance
  typedef enum logic [1:0] {
    DIR_HIZ = 2'b00,
    DIR_IN  = 2'b10,
    DIR_OUT = 2'b11
  } dir_e;

  localparam logic [7:0] PROT_RESET = 8'h80;
endpackage

// File: rtl/pinfn_sync.sv
module pinfn_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pinfn_protect.sv
module pinfn_protect
  import pinfn_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wbits_i,   // {lock, enable} from write data bits 7:6
  output logic       en_o,
  output logic [7:0] rdata_o
);
  logic lock_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= PROT_RESET[7];
      en_q   <= PROT_RESET[6];
    end else if (wr_i) begin
      lock_q <= wbits_i[1];
      if (!lock_q) en_q <= wbits_i[0];
    end
  end

  assign en_o    = en_q;
  assign rdata_o = {lock_q, en_q, 6'b0};

  a_r7_lock_freezes_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(en_q));

  a_r7_lock_writable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (lock_q == $past(wbits_i[1])));
endmodule

// File: rtl/pinfn_port.sv
module pinfn_port
  import pinfn_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           wdata_i,
  input  logic [DIR_BYTES-1:0] dir_we_i,
  input  logic                 odr_we_i,
  input  logic                 mode_we_i,
  input  logic [PINS-1:0]      fn_we_i,
  input  logic [PINS-1:0]      pad_in_i,
  output logic [2*PINS-1:0]    dir_o,
  output logic [PINS-1:0]      odr_o,
  output logic [PINS-1:0]      mode_o,
  output logic [PINS-1:0]      idr_o,
  output logic [8*PINS-1:0]    fn_o,
  output logic [PINS-1:0]      pad_oe_o
);
  logic [2*PINS-1:0] dir_q;
  logic [PINS-1:0]   odr_q, mode_q;
  logic [7:0]        fn_q [PINS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      odr_q  <= '0;
      mode_q <= '0;
      for (int i = 0; i < PINS; i++) fn_q[i] <= '0;
    end else begin
      for (int b = 0; b < DIR_BYTES; b++)
        if (dir_we_i[b]) dir_q[8*b +: 8] <= wdata_i;
      if (odr_we_i)  odr_q  <= wdata_i[PINS-1:0];
      if (mode_we_i) mode_q <= wdata_i[PINS-1:0];
      for (int i = 0; i < PINS; i++)
        if (fn_we_i[i]) fn_q[i] <= wdata_i;
    end
  end

  pinfn_sync #(.W(PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (idr_o)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign pad_oe_o[i]      = ~mode_q[i] & (dir_q[2*i +: 2] == DIR_OUT);
    assign fn_o[8*i +: 8]   = fn_q[i];
  end

  assign dir_o  = dir_q;
  assign odr_o  = odr_q;
  assign mode_o = mode_q;

  // cycles since reset, for the synchronizer latency check
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  a_r5_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (idr_o == $past(pad_in_i, 2)));

  a_r3_oe_rise_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~$past(pad_oe_o)) != '0) |-> $past((|dir_we_i) | mode_we_i));
endmodule

// File: rtl/pinfn_ctrl.sv
module pinfn_ctrl
  import pinfn_pkg::*;
#(
  parameter int NUM_PORTS = 4   // 1..31
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [7:0]                  wdata_i,
  input  logic                        we_i,
  input  logic                        re_i,
  output logic [7:0]                  rdata_o,
  input  logic [NUM_PORTS*PINS-1:0]   pad_in_i,
  output logic [NUM_PORTS*PINS-1:0]   pad_out_o,
  output logic [NUM_PORTS*PINS-1:0]   pad_oe_o,
  output logic [NUM_PORTS*PINS-1:0]   periph_mode_o,
  output logic [NUM_PORTS*PINS*8-1:0] psel_o
);
  localparam int FN_W = PINS * 8;

  logic is_dir, is_odr, is_idr, is_mode, is_fn, is_prot;
  always_comb begin
    is_dir  = (addr_i[11:6] == 6'h00);
    is_odr  = (addr_i[11:5] == 7'h02);
    is_idr  = (addr_i[11:5] == 7'h03);
    is_mode = (addr_i[11:5] == 7'h04);
    is_prot = (addr_i == PROT_ADDR);
    is_fn   = (addr_i[11:8] == 4'h2) && !is_prot;
  end

  logic       prot_en;
  logic [7:0] prot_rd;

  pinfn_protect u_prot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i & is_prot),
    .wbits_i(wdata_i[7:6]),
    .en_o   (prot_en),
    .rdata_o(prot_rd)
  );

  logic [2*PINS-1:0] dir_arr  [NUM_PORTS];
  logic [PINS-1:0]   odr_arr  [NUM_PORTS];
  logic [PINS-1:0]   mode_arr [NUM_PORTS];
  logic [PINS-1:0]   idr_arr  [NUM_PORTS];
  logic [FN_W-1:0]   fn_arr   [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [DIR_BYTES-1:0] dir_we;
    logic [PINS-1:0]      fn_we;
    logic                 dir_hit, fn_hit;

    assign dir_hit = we_i & is_dir & (addr_i[5:1] == 5'(p));
    assign fn_hit  = we_i & is_fn & prot_en & (addr_i[7:3] == 5'(p));
    assign dir_we  = {dir_hit & addr_i[0], dir_hit & ~addr_i[0]};
    assign fn_we   = fn_hit ? (PINS'(1) << addr_i[2:0]) : '0;

    pinfn_port u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wdata_i  (wdata_i),
      .dir_we_i (dir_we),
      .odr_we_i (we_i & is_odr & (addr_i[4:0] == 5'(p))),
      .mode_we_i(we_i & is_mode & (addr_i[4:0] == 5'(p))),
      .fn_we_i  (fn_we),
      .pad_in_i (pad_in_i[p*PINS +: PINS]),
      .dir_o    (dir_arr[p]),
      .odr_o    (odr_arr[p]),
      .mode_o   (mode_arr[p]),
      .idr_o    (idr_arr[p]),
      .fn_o     (fn_arr[p]),
      .pad_oe_o (pad_oe_o[p*PINS +: PINS])
    );

    assign pad_out_o[p*PINS +: PINS]     = odr_arr[p];
    assign periph_mode_o[p*PINS +: PINS] = mode_arr[p];
    assign psel_o[p*FN_W +: FN_W]        = fn_arr[p];
  end

  logic [7:0] rd_mux;
  logic       rd_hit;
  always_comb begin
    rd_mux = '0;
    rd_hit = is_prot;
    if (is_prot) rd_mux = prot_rd;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (is_dir && addr_i[5:1] == 5'(p)) begin
        rd_mux = addr_i[0] ? dir_arr[p][15:8] : dir_arr[p][7:0];
        rd_hit = 1'b1;
      end
      if (is_odr && addr_i[4:0] == 5'(p)) begin
        rd_mux = odr_arr[p];
        rd_hit = 1'b1;
      end
      if (is_idr && addr_i[4:0] == 5'(p)) begin
        rd_mux = idr_arr[p];
        rd_hit = 1'b1;
      end
      if (is_mode && addr_i[4:0] == 5'(p)) begin
        rd_mux = mode_arr[p];
        rd_hit = 1'b1;
      end
      if (is_fn && addr_i[7:3] == 5'(p)) begin
        rd_mux = fn_arr[p][8*addr_i[2:0] +: 8];
        rd_hit = 1'b1;
      end
    end
  end

  logic [7:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
    else           rdata_q <= '0;
  end
  assign rdata_o = rdata_q;

  a_r8_fn_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_en |=> $stable(psel_o));

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_o == 8'h00));

  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !rd_hit) |=> (rdata_o == 8'h00));

  a_r6_periph_no_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & periph_mode_o) == '0);
endmodule

// File: tb/sim_pinfn_ctrl.sv
`timescale 1ns/1ps
module sim_pinfn_ctrl;
  localparam int NP = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [11:0]      addr = '0;
  logic [7:0]       wdata = '0;
  logic             we = 1'b0, re = 1'b0;
  logic [7:0]       rdata;
  logic [NP*8-1:0]  pad_in = '0;
  logic [NP*8-1:0]  pad_out, pad_oe, pmode;
  logic [NP*64-1:0] psel;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pinfn_ctrl #(.NUM_PORTS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .periph_mode_o(pmode),
    .psel_o(psel)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic rchk(string req, logic [11:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    rchk("R1 dir lo", 12'h000, 8'h00);
    rchk("R1 dir hi", 12'h007, 8'h00);
    rchk("R1 odr", 12'h041, 8'h00);
    rchk("R1 mode", 12'h083, 8'h00);
    rchk("R1 fn", 12'h20A, 8'h00);
    rchk("R1 protect", 12'h2FF, 8'h80);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 psel", psel == '0, 1);
    @(negedge clk);
    chk("R10 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_dir;
    // port 1: pin0=11 pin1=10 pin2=00 pin3=11 ; pin4=11
    wr(12'h002, 8'hCB);
    wr(12'h003, 8'h03);
    rchk("R2 dir lo readback", 12'h002, 8'hCB);
    rchk("R2 dir hi readback", 12'h003, 8'h03);
    rchk("R2 other port untouched", 12'h000, 8'h00);
    chk("R3 oe only on 11 codes", pad_oe, 32'h0000_1900);
  endtask

  task automatic t_odr;
    wr(12'h041, 8'hA5);
    wr(12'h043, 8'h3C);
    chk("R4 pad_out", pad_out, 32'h3C00_A500);
    rchk("R4 odr readback", 12'h043, 8'h3C);
  endtask

  task automatic t_mode;
    wr(12'h081, 8'h09);
    chk("R6 periph mode out", pmode, 32'h0000_0900);
    chk("R6 periph removes oe", pad_oe, 32'h0000_1000);
    rchk("R6 mode readback", 12'h081, 8'h09);
    wr(12'h081, 8'h00);
    chk("R3 oe back in gpio mode", pad_oe, 32'h0000_1900);
  endtask

  task automatic t_input;
    @(negedge clk);
    pad_in[23:16] = 8'h5A;
    rchk("R5 not visible after one edge", 12'h062, 8'h00);
    rchk("R5 visible after sync", 12'h062, 8'h5A);
    @(negedge clk);
    pad_in[7:0] = 8'hC3;
    repeat (3) @(negedge clk);
    rchk("R5 port0 input", 12'h060, 8'hC3);
  endtask

  task automatic t_protect;
    wr(12'h2FF, 8'h40);
    rchk("R9 single 0x40 from locked", 12'h2FF, 8'h00);
    wr(12'h208, 8'h11);
    rchk("R8 fn write ignored when disabled", 12'h208, 8'h00);
    wr(12'h2FF, 8'h40);
    rchk("R9 unlocked", 12'h2FF, 8'h40);
    wr(12'h208, 8'h11);
    wr(12'h21F, 8'h7E);
    rchk("R8 fn readback p1n0", 12'h208, 8'h11);
    rchk("R8 fn readback p3n7", 12'h21F, 8'h7E);
    chk("R8 psel p1n0", psel[8*8 +: 8], 8'h11);
    chk("R8 psel p3n7", psel[31*8 +: 8], 8'h7E);
    wr(12'h2FF, 8'hFF);
    rchk("R7 reserved bits read 0", 12'h2FF, 8'hC0);
    wr(12'h2FF, 8'h00);
    rchk("R7 lock guarded enable", 12'h2FF, 8'h40);
    wr(12'h2FF, 8'h00);
    wr(12'h2FF, 8'h80);
    rchk("R9 relocked", 12'h2FF, 8'h80);
    wr(12'h208, 8'h22);
    rchk("R8 fn write ignored after relock", 12'h208, 8'h11);
  endtask

  task automatic t_unmapped;
    wr(12'h044, 8'hFF);
    rchk("R10 odr of absent port", 12'h044, 8'h00);
    wr(12'h008, 8'hFF);
    rchk("R10 dir of absent port", 12'h008, 8'h00);
    wr(12'h100, 8'h55);
    rchk("R10 unmapped addr", 12'h100, 8'h00);
    chk("R10 no state change pad_out", pad_out, 32'h3C00_A500);
    chk("R10 no state change pad_oe", pad_oe, 32'h0000_1900);
    rchk("R10 existing odr intact", 12'h041, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_dir;
    t_odr;
    t_mode;
    t_input;
    t_protect;
    t_unmapped;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule